// File: doc/BRIEF.md
# Speculative Store Undo Log

This block lets a core run ahead of stores that are still waiting for their global acknowledgement. While any store is outstanding, the core reports each change it makes to an architectural register or to a first-level cache line on the log-write port. It gives the value that the location held before the change. The entry goes into a circular buffer. A cache entry, and any speculative cache access reported on the mark port, also sets a bit in a per-block mark table.

An incoming coherence probe is checked against the mark table in the same cycle. A probe to an unmarked block is serviced at once. A probe to a marked block starts a rollback. The log is unwound newest-first, one restore write per cycle on the undo port. Unwinding stops at the log position where the oldest pending store was issued. Probes are held off during the rollback. After it, the block stays in a drain phase: it refuses new speculation until the remaining store has been acknowledged.

The controller has four states. S_IDLE means no store is pending. S_SPEC means stores are pending and logging is active. S_UNDO means a rollback is in progress. S_DRAIN means the rollback is done and the block is waiting for the last acknowledgement. The transitions are:
- S_IDLE to S_SPEC: a store is accepted.
- S_SPEC to S_IDLE: the last pending store is acknowledged.
- S_SPEC to S_UNDO: a probe hits a marked block.
- S_UNDO to S_DRAIN: unwinding has reached the stop position and a store is still pending.
- S_UNDO to S_IDLE: unwinding has reached the stop position and no store is pending.
- S_DRAIN to S_IDLE: the pending store is acknowledged.

Top module: `spec_undo_log`

## Requirements
- R1: After reset the log and the pending-store list are empty, and core_stall, probe_stall and undo_valid are low.
- R2: A log write is accepted only in S_SPEC, or in S_IDLE in the same cycle as an accepted store issue. At any other time it is dropped and sets no mark.
- R3: An entry keeps a type bit (1 = cache line, 0 = register), the index, the old data, and a tag. The tag is (k-1) mod 2^ST_AW, where k counts the stores accepted since reset up to and including that cycle. Undo writes return these four fields unchanged.
- R4: When the log holds 2^LOG_AW entries, core_stall is high and further log writes are dropped.
- R5: At most 2^ST_AW stores may be pending. When the list is full, core_stall is high and further store issues are dropped.
- R6: Acknowledgements retire stores in issue order. Log entries older than the next pending store's issue position are retired. When no store remains pending, the whole log is retired, all marks are cleared and the state returns to S_IDLE.
- R7: A probe to an unmarked block sees probe_stall low in the same cycle and causes no rollback.
- R8: A probe in S_SPEC to a marked block sees probe_stall high in that cycle, and the state is S_UNDO from the next cycle.
- R9: Rollback emits one undo write per cycle, newest entry first. It stops at the issue position of the oldest pending store. Entries older than that position are kept.
- R10: probe_stall is high in every S_UNDO cycle, including the final cycle, which has no undo write.
- R11: A rollback discards every pending store except the oldest. In S_DRAIN, core_stall is high and both log writes and store issues are dropped, until the acknowledgement returns the block to S_IDLE.
- R12: Marks are set by accepted cache-type log entries and by mark-port accesses while speculation is active. A rollback clears all marks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| log_valid | input | 1 | Log-write request |
| log_is_cache | input | 1 | 1 = cache line entry, 0 = register entry |
| log_index | input | IDX_W | Register number or cache block index |
| log_old | input | DATA_W | Value held before the change |
| acc_valid | input | 1 | Speculative cache access to mark |
| acc_block | input | IDX_W | Block index of that access |
| st_issue | input | 1 | Store issued |
| st_ack | input | 1 | Oldest pending store acknowledged |
| probe_valid | input | 1 | Coherence probe present |
| probe_block | input | IDX_W | Block index of the probe |
| probe_stall | output | 1 | Probe must be held, not serviced |
| core_stall | output | 1 | Core must not log or issue stores |
| undo_valid | output | 1 | Restore write valid |
| undo_is_cache | output | 1 | Type of the restore target |
| undo_index | output | IDX_W | Restore target index |
| undo_data | output | DATA_W | Value to write back |
| undo_tag | output | ST_AW | Tag of the store that the entry followed |

## Verification
The bench builds the block with LOG_AW=2 and ST_AW=1, so the log has four entries and at most two stores can be pending. With these values a full log and a full store list each take only a few cycles to reach. The one-bit tag also wraps within the run, which shows the store numbering in the undo output. IDX_W=4 and DATA_W=8 leave enough distinct blocks to probe marked and unmarked lines side by side.

// File: rtl/spec_undo_pkg.sv
package spec_undo_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_SPEC,
        S_UNDO,
        S_DRAIN
    } sul_state_e;
endpackage

// File: rtl/spec_log_ram.sv
module spec_log_ram #(
    parameter int AW = 3,
    parameter int W  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          pop_en,
    input  logic          head_ld,
    input  logic [AW:0]   head_val,
    output logic [AW:0]   tail_o,
    output logic          full_o,
    output logic          empty_o,
    output logic [W-1:0]  top_data
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem_q [DEPTH];
    logic [AW:0]  head_q, tail_q, used, tail_m1;

    assign used    = tail_q - head_q;
    assign full_o  = used[AW];
    assign empty_o = (used == '0);
    assign tail_m1 = tail_q - (AW+1)'(1);
    assign tail_o  = tail_q;
    assign top_data = mem_q[tail_m1[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[tail_q[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (wr_en)       tail_q <= tail_q + (AW+1)'(1);
            else if (pop_en) tail_q <= tail_m1;
            if (head_ld)     head_q <= head_val;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full_o); // R4
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> !empty_o); // R9
endmodule

// File: rtl/spec_store_list.sv
module spec_store_list #(
    parameter int SW = 2,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [PW-1:0] push_pos,
    input  logic          pop,
    input  logic          trim,
    output logic [PW-1:0] oldest_pos,
    output logic [PW-1:0] next_pos,
    output logic [SW:0]   cnt_o,
    output logic          full_o
);
    localparam int SD = 1 << SW;

    logic [PW-1:0] pos_q [SD];
    logic [SW-1:0] rd_q, wr_q, rd_p1;
    logic [SW:0]   cnt_q;

    assign rd_p1      = rd_q + SW'(1);
    assign oldest_pos = pos_q[rd_q];
    assign next_pos   = pos_q[rd_p1];
    assign cnt_o      = cnt_q;
    assign full_o     = (cnt_q == (SW+1)'(SD));

    always_ff @(posedge clk) begin
        if (push) pos_q[wr_q] <= push_pos;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else if (trim) begin
            wr_q  <= rd_p1;
            rd_q  <= pop ? rd_p1 : rd_q;
            cnt_q <= pop ? '0 : (SW+1)'(1);
        end else begin
            if (push) wr_q <= wr_q + SW'(1);
            if (pop)  rd_q <= rd_p1;
            cnt_q <= cnt_q + (SW+1)'(push) - (SW+1)'(pop);
        end
    end

    AST_LIST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full_o); // R5
    AST_LIST_POP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0)); // R6
    AST_TRIM_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        trim |-> !push); // R11
endmodule

// File: rtl/spec_mark_table.sv
module spec_mark_table #(
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_a,
    input  logic [BW-1:0] blk_a,
    input  logic          set_b,
    input  logic [BW-1:0] blk_b,
    input  logic          clr,
    input  logic [BW-1:0] q_blk,
    output logic          hit,
    output logic          any
);
    localparam int NB = 1 << BW;

    logic [NB-1:0] mark_q, set_vec;

    for (genvar g = 0; g < NB; g++) begin : g_set
        assign set_vec[g] = (set_a && (blk_a == BW'(g))) ||
                            (set_b && (blk_b == BW'(g)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   mark_q <= '0;
        else if (clr) mark_q <= '0;
        else          mark_q <= mark_q | set_vec;
    end

    assign hit = mark_q[q_blk];
    assign any = |mark_q;

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !any); // R12
endmodule

// File: rtl/spec_undo_log.sv
module spec_undo_log
    import spec_undo_pkg::*;
#(
    parameter int LOG_AW = 3,
    parameter int ST_AW  = 2,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              log_valid,
    input  logic              log_is_cache,
    input  logic [IDX_W-1:0]  log_index,
    input  logic [DATA_W-1:0] log_old,
    input  logic              acc_valid,
    input  logic [IDX_W-1:0]  acc_block,
    input  logic              st_issue,
    input  logic              st_ack,
    input  logic              probe_valid,
    input  logic [IDX_W-1:0]  probe_block,
    output logic              probe_stall,
    output logic              core_stall,
    output logic              undo_valid,
    output logic              undo_is_cache,
    output logic [IDX_W-1:0]  undo_index,
    output logic [DATA_W-1:0] undo_data,
    output logic [ST_AW-1:0]  undo_tag
);
    localparam int PW = LOG_AW + 1;
    localparam int EW = 1 + IDX_W + DATA_W + ST_AW;
    localparam int CW = ST_AW + 2;

    sul_state_e state_q, state_d;

    logic [PW-1:0]    tail_w, tail_next, oldest_pos, next_pos, stop_q, head_val;
    logic [EW-1:0]    wr_entry, top_entry;
    logic [ST_AW:0]   st_cnt;
    logic [ST_AW-1:0] seq_q, tag_now;
    logic [CW-1:0]    st_left;
    logic log_full, log_empty, st_full, mark_hit, mark_any;
    logic hit, spec_now, st_acc, log_acc, acc_acc, ack_ok, head_ld, clr, at_stop;

    // -------- acceptance decode --------
    assign hit      = probe_valid && (state_q == S_SPEC) && mark_hit;
    assign st_acc   = st_issue && ((state_q == S_IDLE) || (state_q == S_SPEC))
                      && !st_full && !hit;
    assign spec_now = (state_q == S_SPEC) || ((state_q == S_IDLE) && st_acc);
    assign log_acc  = log_valid && spec_now && !log_full && !hit;
    assign acc_acc  = acc_valid && spec_now && !hit;
    assign ack_ok   = st_ack && (st_cnt != '0);
    assign st_left  = CW'(st_cnt) - CW'(ack_ok) + CW'(st_acc);
    assign tail_next = tail_w + PW'(log_acc);
    assign at_stop  = (tail_w == stop_q);
    assign tag_now  = st_acc ? seq_q : seq_q - ST_AW'(1);
    assign wr_entry = {log_is_cache, log_index, log_old, tag_now};

    // -------- retire and clear control --------
    always_comb begin
        head_ld  = 1'b0;
        head_val = tail_next;
        if ((state_q == S_SPEC) && !hit && ack_ok) begin
            head_ld = 1'b1;
            if (st_left == '0)
                head_val = tail_next;
            else if (st_cnt >= (ST_AW+1)'(2))
                head_val = next_pos;
            else
                head_val = tail_w;
        end
    end

    assign clr = hit || ((state_q == S_SPEC) && ack_ok && (st_left == '0));

    // -------- state register --------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (st_acc) state_d = S_SPEC;
            S_SPEC: begin
                if (hit)                           state_d = S_UNDO;
                else if (ack_ok && st_left == '0)  state_d = S_IDLE;
            end
            S_UNDO:  if (at_stop) state_d = (st_left == '0) ? S_IDLE : S_DRAIN;
            S_DRAIN: if (st_left == '0) state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= '0;
            seq_q  <= '0;
        end else begin
            if (hit)    stop_q <= oldest_pos;
            if (st_acc) seq_q  <= seq_q + ST_AW'(1);
        end
    end

    // -------- outputs --------
    always_comb begin
        probe_stall = (state_q == S_UNDO) || hit;
        core_stall  = log_full || st_full || hit ||
                      (state_q == S_UNDO) || (state_q == S_DRAIN);
        undo_valid  = (state_q == S_UNDO) && !at_stop;
        {undo_is_cache, undo_index, undo_data, undo_tag} = top_entry;
    end

    // -------- submodules --------
    spec_log_ram #(.AW(LOG_AW), .W(EW)) u_log (
        .clk(clk), .rst_n(rst_n),
        .wr_en(log_acc), .wr_data(wr_entry),
        .pop_en(undo_valid),
        .head_ld(head_ld), .head_val(head_val),
        .tail_o(tail_w), .full_o(log_full), .empty_o(log_empty),
        .top_data(top_entry)
    );

    spec_store_list #(.SW(ST_AW), .PW(PW)) u_stores (
        .clk(clk), .rst_n(rst_n),
        .push(st_acc), .push_pos(tail_w),
        .pop(ack_ok), .trim(hit),
        .oldest_pos(oldest_pos), .next_pos(next_pos),
        .cnt_o(st_cnt), .full_o(st_full)
    );

    spec_mark_table #(.BW(IDX_W)) u_marks (
        .clk(clk), .rst_n(rst_n),
        .set_a(log_acc && log_is_cache), .blk_a(log_index),
        .set_b(acc_acc), .blk_b(acc_block),
        .clr(clr), .q_blk(probe_block),
        .hit(mark_hit), .any(mark_any)
    );

    // -------- assertions --------
    AST_UNDO_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        undo_valid |-> probe_stall); // R10
    AST_ROLLBACK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SPEC && probe_stall) |=> (state_q == S_UNDO)); // R8
    AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> (!mark_any && log_empty)); // R6
    AST_UNDO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        undo_valid |=> (tail_w == $past(tail_w) - PW'(1))); // R9
    AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DRAIN) |-> log_empty); // R11
endmodule

// File: tb/sim_spec_undo_log.sv
module sim_spec_undo_log;
    localparam int LOG_AW = 2;
    localparam int ST_AW  = 1;
    localparam int IDX_W  = 4;
    localparam int DATA_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic log_valid = 1'b0, log_is_cache = 1'b0;
    logic [IDX_W-1:0] log_index = '0;
    logic [DATA_W-1:0] log_old = '0;
    logic acc_valid = 1'b0;
    logic [IDX_W-1:0] acc_block = '0;
    logic st_issue = 1'b0, st_ack = 1'b0;
    logic probe_valid = 1'b0;
    logic [IDX_W-1:0] probe_block = '0;
    logic probe_stall, core_stall, undo_valid, undo_is_cache;
    logic [IDX_W-1:0] undo_index;
    logic [DATA_W-1:0] undo_data;
    logic [ST_AW-1:0] undo_tag;

    int total = 0;
    int bad = 0;
    int nst = 0;

    always #5 clk = ~clk;

    spec_undo_log #(.LOG_AW(LOG_AW), .ST_AW(ST_AW), .IDX_W(IDX_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .log_valid(log_valid), .log_is_cache(log_is_cache),
        .log_index(log_index), .log_old(log_old),
        .acc_valid(acc_valid), .acc_block(acc_block),
        .st_issue(st_issue), .st_ack(st_ack),
        .probe_valid(probe_valid), .probe_block(probe_block),
        .probe_stall(probe_stall), .core_stall(core_stall),
        .undo_valid(undo_valid), .undo_is_cache(undo_is_cache),
        .undo_index(undo_index), .undo_data(undo_data), .undo_tag(undo_tag)
    );

    // {is_cache, index, old data}
    localparam logic [12:0] TBL [3] = '{
        {1'b1, 4'd5, 8'h11},
        {1'b0, 4'd2, 8'h22},
        {1'b1, 4'd7, 8'h33}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_store(input bit counts);
        st_issue = 1'b1;
        tick();
        st_issue = 1'b0;
        if (counts) nst++;
    endtask

    task automatic do_ack();
        st_ack = 1'b1;
        tick();
        st_ack = 1'b0;
    endtask

    task automatic do_log(input logic c, input logic [IDX_W-1:0] i, input logic [DATA_W-1:0] d);
        log_valid = 1'b1; log_is_cache = c; log_index = i; log_old = d;
        tick();
        log_valid = 1'b0;
    endtask

    task automatic probe_chk(input string req, input logic [IDX_W-1:0] b, input logic exp);
        probe_valid = 1'b1; probe_block = b;
        #1;
        chk(req, probe_stall, exp);
        tick();
        probe_valid = 1'b0;
    endtask

    task automatic undo_chk(input string req, input logic c, input logic [IDX_W-1:0] i,
                            input logic [DATA_W-1:0] d, input logic [ST_AW-1:0] t);
        chk({req, " undo_valid"}, undo_valid, 1);
        chk({req, " type"}, undo_is_cache, c);
        chk({req, " index"}, undo_index, i);
        chk({req, " data"}, undo_data, d);
        chk({req, " tag"}, undo_tag, t);
        chk("R10 stall during undo", probe_stall, 1);
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 core_stall", core_stall, 0);
        chk("R1 probe_stall", probe_stall, 0);
        chk("R1 undo_valid", undo_valid, 0);

        // R2 log in idle dropped, leaves no mark
        do_log(1'b1, 4'd5, 8'hAA);
        do_store(1);
        probe_chk("R2 idle log dropped", 4'd5, 0);

        // table-driven logging, then rollback newest-first (R3, R9)
        for (int k = 0; k < 3; k++) do_log(TBL[k][12], TBL[k][11:8], TBL[k][7:0]);
        probe_chk("R7 unmarked probe passes", 4'd9, 0);
        probe_chk("R8 marked probe stalls", 4'd7, 1);
        for (int k = 2; k >= 0; k--)
            undo_chk("R3 R9 entry", TBL[k][12], TBL[k][11:8], TBL[k][7:0], ST_AW'(nst - 1));
        chk("R9 stop no write", undo_valid, 0);
        chk("R10 stall final undo cycle", probe_stall, 1);
        tick();
        chk("R11 drain core_stall", core_stall, 1);
        chk("R11 drain probes pass", probe_stall, 0);
        do_log(1'b1, 4'd3, 8'h55);
        do_store(0);
        chk("R11 still draining", core_stall, 1);
        do_ack();
        chk("R11 drained", core_stall, 0);
        do_store(1);
        probe_chk("R11 drain log dropped", 4'd3, 0);
        probe_chk("R12 rollback cleared marks", 4'd5, 0);

        // R9 stop at oldest pending store, R5 list full
        do_log(1'b1, 4'd1, 8'h41);
        do_store(1);
        do_log(1'b1, 4'd2, 8'h42);
        chk("R5 list full stalls", core_stall, 1);
        do_store(0);
        do_ack();
        chk("R5 extra store dropped", core_stall, 0);
        probe_chk("R6 retained mark hits", 4'd1, 1);
        undo_chk("R9 newest only", 1'b1, 4'd2, 8'h42, ST_AW'(nst - 1));
        chk("R9 older entry kept", undo_valid, 0);
        tick();
        do_ack();
        chk("R6 back to idle", core_stall, 0);

        // R4 log full
        do_store(1);
        for (int k = 0; k < 4; k++) do_log(1'b1, IDX_W'(8 + k), DATA_W'(k));
        chk("R4 full stalls", core_stall, 1);
        do_log(1'b1, 4'd12, 8'h99);
        probe_chk("R4 write when full dropped", 4'd12, 0);
        chk("R7 no rollback started", undo_valid, 0);
        do_ack();
        chk("R6 retire all", core_stall, 0);
        do_store(1);
        probe_chk("R6 marks cleared after drain", 4'd8, 0);
        do_ack();

        // R12 mark port, rollback with no entries
        do_store(1);
        acc_valid = 1'b1; acc_block = 4'd13;
        tick();
        acc_valid = 1'b0;
        probe_chk("R12 access mark hits", 4'd13, 1);
        chk("R9 empty rollback no write", undo_valid, 0);
        chk("R10 stall empty rollback", probe_stall, 1);
        tick();
        chk("R11 drain after empty rollback", core_stall, 1);
        do_ack();
        chk("R11 idle after ack", core_stall, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule